// File: doc/BRIEF.md
# Vector Type Configuration Register

This block holds the type word that tells a vector unit how to interpret its register file: the element width, the register-group multiplier, and the tail and mask policy bits. The configuration instructions are the only way to change it. They present a requested type word together with an update strobe. The block decides in the same cycle whether the unit can support that request. On the next clock edge it stores either the requested fields or the illegal-configuration marker.

When the marker is stored, it sits in the sign bit, bit XLEN-1, and every other bit reads as zero. Software can therefore test the marker with a single sign-bit branch. The stored word is always visible on a read port for CSR reads. The block also gives a combinational per-instruction check: while the marker is set, it raises an illegal-instruction indication for any valid vector instruction that depends on the type. XLEN is a parameter and can be 32 or 64.

Top module: `vtype_cfg_reg`

## Requirements
- R1: After reset the read port shows bit XLEN-1 set and all other bits zero.
- R2: An accepted request is stored on the clock edge that samples the strobe. Afterwards bits 7:0 read back the request unchanged and every other bit reads zero. The field positions are: multiplier code in 2:0, element-width code in 5:3, tail policy in bit 6, mask policy in bit 7.
- R3: An element-width code with bit 5 set (values 1xx) is unsupported. Codes 000, 001, 010 and 011 mean 8, 16, 32 and 64 bits.
- R4: Multiplier code 100 is unsupported. Integer codes 000, 001, 010 and 011 (1, 2, 4, 8) are accepted with every supported element width.
- R5: Fractional codes 111 (1/2), 110 (1/4) and 101 (1/8) are rejected when the element width divided by the fraction exceeds 64 bits. Otherwise they are accepted.
- R6: A request with any bit set between bit 8 and bit XLEN-2 is unsupported.
- R7: An unsupported request stores bit XLEN-1 set with all other bits zero.
- R8: Without the update strobe the stored word does not change, whatever the request input carries.
- R9: The illegal-instruction output is high exactly when an instruction is valid, depends on the type, and the stored bit XLEN-1 is set.
- R10: A request with bit XLEN-1 set is unsupported.
- R11: In the cycle an update is strobed, the instruction check still uses the previously stored word. The new word governs it from the next cycle.
- R12: With XLEN=32 the marker sits in bit 31 and the stored word is 32 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_upd | input | 1 | Configuration-instruction update strobe |
| cfg_req | input | XLEN | Requested type word |
| csr_rd_data | output | XLEN | Current stored type word |
| insn_valid | input | 1 | A vector instruction is being checked |
| insn_uses_vtype | input | 1 | That instruction depends on the type |
| insn_illegal | output | 1 | Illegal-instruction indication |

## Verification
Two functions can fall in the same cycle: a configuration update, and the illegal-instruction check of an instruction that depends on the type. The bench provokes this by raising the strobe and a dependent instruction together. It does this once from the illegal state with a supported request, and once from a legal state with an unsupported request. Before the edge, the check output must reflect the old word. After the edge it must reflect the new word.

// File: rtl/vtype_cfg_pkg.sv
package vtype_cfg_pkg;

  localparam int unsigned VT_FIELD_W = 8;

  typedef struct packed {
    logic       mask_pol;
    logic       tail_pol;
    logic [2:0] sew_code;
    logic [2:0] lmul_code;
  } vt_fields_t;

  // element width in bits for a supported width code
  function automatic int unsigned sew_width(logic [2:0] code);
    return 32'd8 << code[1:0];
  endfunction

  // codes 101/110/111 are fractional multipliers
  function automatic bit lmul_is_frac(logic [2:0] code);
    return code[2] && (code[1:0] != 2'b00);
  endfunction

  // log2 of the fraction denominator: 111->1, 110->2, 101->3
  function automatic int unsigned frac_shift(logic [2:0] code);
    return 32'd4 - 32'(code[1:0]);
  endfunction

  function automatic bit fields_supported(vt_fields_t f, int unsigned elen_max);
    if (f.sew_code[2]) return 1'b0;
    if (f.lmul_code == 3'b100) return 1'b0;
    if (lmul_is_frac(f.lmul_code))
      return (sew_width(f.sew_code) << frac_shift(f.lmul_code)) <= elen_max;
    return 1'b1;
  endfunction

endpackage

// File: rtl/vtype_req_check.sv
module vtype_req_check
  import vtype_cfg_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned ELEN_MAX = 64
) (
  input  logic [XLEN-1:0] req,
  output vt_fields_t      fields,
  output logic            req_ok
);
  localparam int unsigned RSV_LO = VT_FIELD_W;
  localparam int unsigned RSV_HI = XLEN - 2;

  logic rsv_clear;
  logic top_clear;

  assign fields    = vt_fields_t'(req[VT_FIELD_W-1:0]);
  assign rsv_clear = ~|req[RSV_HI:RSV_LO];
  assign top_clear = ~req[XLEN-1];
  assign req_ok    = rsv_clear && top_clear && fields_supported(fields, ELEN_MAX);
endmodule

// File: rtl/vtype_state.sv
module vtype_state
  import vtype_cfg_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            upd_en,
  input  logic            upd_ok,
  input  vt_fields_t      upd_fields,
  output logic [XLEN-1:0] value,
  output logic            ill_flag
);
  localparam int unsigned PAD_W = XLEN - 1 - VT_FIELD_W;

  logic       ill_q;
  vt_fields_t fields_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ill_q    <= 1'b1;
      fields_q <= '0;
    end else if (upd_en) begin
      ill_q    <= ~upd_ok;
      fields_q <= upd_ok ? upd_fields : '0;
    end
  end

  assign value    = {ill_q, {PAD_W{1'b0}}, fields_q};
  assign ill_flag = ill_q;
endmodule

// File: rtl/vtype_insn_gate.sv
module vtype_insn_gate (
  input  logic insn_valid,
  input  logic insn_dep,
  input  logic ill_flag,
  output logic trap
);
  assign trap = insn_valid && insn_dep && ill_flag;
endmodule

// File: rtl/vtype_cfg_reg.sv
module vtype_cfg_reg
  import vtype_cfg_pkg::*;
#(
  parameter int unsigned XLEN     = 64,
  parameter int unsigned ELEN_MAX = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_upd,
  input  logic [XLEN-1:0] cfg_req,
  output logic [XLEN-1:0] csr_rd_data,
  input  logic            insn_valid,
  input  logic            insn_uses_vtype,
  output logic            insn_illegal
);
  vt_fields_t req_fields_w;
  logic       req_ok_w;
  logic       ill_flag_w;

  vtype_req_check #(.XLEN(XLEN), .ELEN_MAX(ELEN_MAX)) req_chk_u (
    .req    (cfg_req),
    .fields (req_fields_w),
    .req_ok (req_ok_w)
  );

  vtype_state #(.XLEN(XLEN)) state_u (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_en     (cfg_upd),
    .upd_ok     (req_ok_w),
    .upd_fields (req_fields_w),
    .value      (csr_rd_data),
    .ill_flag   (ill_flag_w)
  );

  vtype_insn_gate gate_u (
    .insn_valid (insn_valid),
    .insn_dep   (insn_uses_vtype),
    .ill_flag   (ill_flag_w),
    .trap       (insn_illegal)
  );
endmodule

// File: rtl/vtype_cfg_reg_chk.sv
module vtype_cfg_reg_chk #(
  parameter int unsigned XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_upd,
  input logic [XLEN-1:0] cfg_req,
  input logic [XLEN-1:0] csr_rd_data,
  input logic            insn_valid,
  input logic            insn_uses_vtype,
  input logic            insn_illegal,
  input logic            req_ok
);
  localparam logic [XLEN-1:0] RST_WORD = {1'b1, {(XLEN-1){1'b0}}};

  assert_reset_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> csr_rd_data == RST_WORD);

  assert_accept_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_upd && req_ok |=> csr_rd_data == XLEN'($past(cfg_req[7:0])));

  assert_sew_reserved_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_upd && cfg_req[5] |=> csr_rd_data == RST_WORD);

  assert_lmul_reserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_upd && cfg_req[2:0] == 3'b100 |=> csr_rd_data == RST_WORD);

  assert_flag_clears_rest_R7: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rd_data[XLEN-1] |-> csr_rd_data[XLEN-2:0] == '0);

  assert_hold_no_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_upd |=> $stable(csr_rd_data));

  assert_trap_raised_R9: assert property (@(posedge clk) disable iff (!rst_n)
    insn_valid && insn_uses_vtype && csr_rd_data[XLEN-1] |-> insn_illegal);

  assert_trap_only_when_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    insn_illegal |-> insn_valid && insn_uses_vtype && csr_rd_data[XLEN-1]);

  assert_top_bit_request_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_upd && cfg_req[XLEN-1] |=> csr_rd_data[XLEN-1]);
endmodule

bind vtype_cfg_reg vtype_cfg_reg_chk #(.XLEN(XLEN)) chk_i (
  .clk             (clk),
  .rst_n           (rst_n),
  .cfg_upd         (cfg_upd),
  .cfg_req         (cfg_req),
  .csr_rd_data     (csr_rd_data),
  .insn_valid      (insn_valid),
  .insn_uses_vtype (insn_uses_vtype),
  .insn_illegal    (insn_illegal),
  .req_ok          (req_ok_w)
);

// File: tb/vtype_cfg_reg_tb_top.sv
module vtype_cfg_reg_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_upd = 1'b0;
  logic [63:0] cfg_req = '0;
  logic [63:0] rd64;
  logic        insn_valid = 1'b0;
  logic        insn_dep = 1'b0;
  logic        ill64;
  logic        cfg_upd32 = 1'b0;
  logic [31:0] cfg_req32 = '0;
  logic [31:0] rd32;
  logic        ill32;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  localparam logic [63:0] ILL64 = 64'h8000_0000_0000_0000;

  always #10 clk = ~clk;

  vtype_cfg_reg #(.XLEN(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_upd(cfg_upd), .cfg_req(cfg_req),
    .csr_rd_data(rd64), .insn_valid(insn_valid), .insn_uses_vtype(insn_dep),
    .insn_illegal(ill64));

  vtype_cfg_reg #(.XLEN(32)) dut32_i (
    .clk(clk), .rst_n(rst_n), .cfg_upd(cfg_upd32), .cfg_req(cfg_req32),
    .csr_rd_data(rd32), .insn_valid(insn_valid), .insn_uses_vtype(insn_dep),
    .insn_illegal(ill32));

  // expected stored word, derived from the requirements
  function automatic logic [63:0] model(logic [63:0] req, int xlen);
    int sew;
    int denom;
    bit ok = 1'b1;
    case (req[5:3])
      3'd0: sew = 8;
      3'd1: sew = 16;
      3'd2: sew = 32;
      3'd3: sew = 64;
      default: begin sew = 0; ok = 1'b0; end
    endcase
    case (req[2:0])
      3'b100: begin denom = 0; ok = 1'b0; end
      3'b101: denom = 8;
      3'b110: denom = 4;
      3'b111: denom = 2;
      default: denom = 0;
    endcase
    if (denom != 0 && sew * denom > 64) ok = 1'b0;
    for (int b = 8; b <= xlen - 2; b++) if (req[b]) ok = 1'b0;
    if (req[xlen-1]) ok = 1'b0;
    return ok ? {56'd0, req[7:0]} : (64'd1 << (xlen - 1));
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write64(logic [63:0] r);
    @(negedge clk);
    cfg_upd = 1'b1;
    cfg_req = r;
    @(negedge clk);
    cfg_upd = 1'b0;
  endtask

  task automatic write_check(string tag, logic [63:0] r);
    write64(r);
    check(tag, rd64, model(r, 64));
  endtask

  task automatic t_reset();
    check("R1 reset word", rd64, ILL64);
    insn_valid = 1'b1; insn_dep = 1'b1; #1;
    check("R9 trap after reset", {63'd0, ill64}, 64'd1);
    insn_valid = 1'b0; insn_dep = 1'b0;
  endtask

  task automatic t_legal();
    write_check("R2 sew64 lmul1 mask-agnostic", 64'h98);
    check("R2 exact word", rd64, 64'h98);
    for (int l = 0; l < 4; l++)
      for (int s = 0; s < 4; s++)
        write_check("R4 integer lmul accepted", {58'd0, 3'(s), 3'(l)} | 64'h40);
    write_check("R5 lmul 1/2 sew8 tail-agnostic", 64'h47);
    insn_valid = 1'b1; insn_dep = 1'b1; #1;
    check("R9 no trap when legal", {63'd0, ill64}, 64'd0);
    insn_valid = 1'b0; insn_dep = 1'b0;
  endtask

  task automatic t_sew_rsv();
    write_check("R3 sew code 100", 64'h20);
    check("R7 illegal word", rd64, ILL64);
    write64(64'h08);
    write_check("R3 sew code 111 with fields", 64'hF8);
    check("R7 fields cleared", rd64, ILL64);
  endtask

  task automatic t_lmul();
    write64(64'h08);
    write_check("R4 lmul code 100", 64'h0C);
    check("R4 lmul 100 illegal", rd64, ILL64);
  endtask

  task automatic t_frac();
    write_check("R5 sew64 lmul1/2", 64'h1F);
    write_check("R5 sew32 lmul1/2", 64'h17);
    write_check("R5 sew16 lmul1/8", 64'h0D);
    write_check("R5 sew8 lmul1/8", 64'h05);
    write_check("R5 sew16 lmul1/4", 64'h0E);
    write_check("R5 sew32 lmul1/4", 64'h16);
    write_check("R5 sew64 lmul1/8", 64'h1D);
  endtask

  task automatic t_rsv_bits();
    write64(64'h08);
    write_check("R6 bit 8 set", 64'h108);
    write64(64'h08);
    write_check("R6 bit 62 set", (64'd1 << 62) | 64'h08);
    check("R6 bit 62 word", rd64, ILL64);
  endtask

  task automatic t_top_bit();
    write64(64'h08);
    write_check("R10 top bit requested", ILL64 | 64'h08);
  endtask

  task automatic t_hold();
    write64(64'h59);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      cfg_req = (i % 2 == 0) ? 64'h20 : 64'h0A;
    end
    @(negedge clk);
    check("R8 no strobe keeps word", rd64, 64'h59);
  endtask

  task automatic t_same_cycle();
    write64(64'h20);
    @(negedge clk);
    cfg_upd = 1'b1; cfg_req = 64'h10;
    insn_valid = 1'b1; insn_dep = 1'b1; #1;
    check("R11 old illegal word traps", {63'd0, ill64}, 64'd1);
    @(negedge clk);
    cfg_upd = 1'b0; #1;
    check("R11 new legal word no trap", {63'd0, ill64}, 64'd0);
    check("R11 stored word", rd64, 64'h10);
    cfg_upd = 1'b1; cfg_req = 64'h24; #1;
    check("R11 old legal word no trap", {63'd0, ill64}, 64'd0);
    @(negedge clk);
    cfg_upd = 1'b0; #1;
    check("R11 new illegal word traps", {63'd0, ill64}, 64'd1);
    insn_dep = 1'b0; #1;
    check("R9 no trap without dependence", {63'd0, ill64}, 64'd0);
    insn_dep = 1'b1; insn_valid = 1'b0; #1;
    check("R9 no trap without valid", {63'd0, ill64}, 64'd0);
    insn_dep = 1'b0;
  endtask

  task automatic t_xlen32();
    check("R12 reset word 32", {32'd0, rd32}, 64'h8000_0000);
    @(negedge clk); cfg_upd32 = 1'b1; cfg_req32 = 32'h98;
    @(negedge clk); cfg_upd32 = 1'b0;
    check("R12 legal 32", {32'd0, rd32}, model(64'h98, 32));
    @(negedge clk); cfg_upd32 = 1'b1; cfg_req32 = 32'h4000_0008;
    @(negedge clk); cfg_upd32 = 1'b0;
    check("R12 R6 bit 30 set", {32'd0, rd32}, 64'h8000_0000);
    insn_valid = 1'b1; insn_dep = 1'b1; #1;
    check("R12 trap on 32", {63'd0, ill32}, 64'd1);
    insn_valid = 1'b0; insn_dep = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_legal();
    t_sew_rsv();
    t_lmul();
    t_frac();
    t_rsv_bits();
    t_top_bit();
    t_hold();
    t_same_cycle();
    t_xlen32();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule